// File: doc/BRIEF.md
# Edge-Latched Vectored Interrupt Arbiter

The block collects interrupt events from a parameterized number of sources and holds each one as a pending flag until it is serviced. Each request input goes through a synchronizer and a rising-edge detector, so one assertion of a request line sets its flag once. Flags keep latching while a source is masked or while interrupts are globally off. A backlog therefore builds up and is later drained in a deterministic order.

Arbitration considers only sources that are both pending and enabled. A per-source level bit splits the sources into a high group and a low group. Any eligible high-group source beats any low-group source. Within a group, the lowest source index wins.

The CPU sees a registered `irq_o` and a vector index. It answers with an acknowledge pulse, which enters service, and later with a return pulse. Entering service turns the global enable off. A high-group source can preempt a low-group handler once software turns the global enable back on inside that handler. Software reaches the state through a plain register write port and a combinational read port.

Top module: `irq_vec_ctrl`

## Requirements
- R1: A rising edge on `req_i[i]` sets pending bit i once. A level held high does not set the bit again after it has been cleared. Pending bits are read at address 0, with bit i belonging to source i.
- R2: A pending bit latches its event whatever the value of its enable bit and of the global enable.
- R3: Only sources that are both pending and enabled are eligible. Within one group, the eligible source with the lowest index is presented on `vec_o`.
- R4: The level bits are at address 2, where 1 means high group. Any eligible high-group source is chosen over every low-group source.
- R5: `irq_o` rises only while the global enable is 1. `irq_o` stays low whenever no source is eligible, or when a handler is in service and preemption is not allowed.
- R6: While `irq_o` is high, `vec_o` is stable until `ack_i`. The acknowledge cycle clears the chosen pending bit, drops `irq_o`, clears the global enable, and sets the in-service bit of the chosen group.
- R7: When the global enable is set again, the backlog of eligible pending sources is served one source per acknowledge, in the R3/R4 order.
- R8: While only a low-group handler is in service and the global enable is 1, a high-group source may be presented. A low-group source may not.
- R9: `reti_i` clears the high in-service bit if it is set, and otherwise the low in-service bit. It also sets the global enable.
- R10: Writing 1 to a bit at address 0 clears that pending bit. A request event in the same cycle wins, and the bit stays set.
- R11: Enables are at address 1. Address 3 is control: bit 0 is the global enable (read/write), bit 1 is the low in-service bit and bit 2 is the high in-service bit (both read-only). Every register resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | N | Asynchronous request lines, rising edge is an event |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register write address |
| wr_data_i | input | N | Register write data |
| rd_addr_i | input | 2 | Register read address |
| rd_data_o | output | N | Register read data (combinational) |
| irq_o | output | 1 | Interrupt request to CPU |
| vec_o | output | $clog2(N) | Index of presented source |
| ack_i | input | 1 | CPU acknowledge, enters service |
| reti_i | input | 1 | CPU return from handler |

## Verification
The bench first drives simultaneous events with every level bit 0. This checks pure index ordering. Random enable and level masks combined with random event bursts, built up while interrupts are globally off, then check that each drained vector matches a group-then-index model and that nothing is presented once the backlog is empty. A masked-then-enabled source shows that masking defers service and does not lose the event. A request edge that lands in the same cycle as a software clear tells event priority apart from clear priority. A nested sequence with one low-group source and one high-group source shows that preemption is allowed across groups and refused within a group. It also shows that the in-service bits unwind in order.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  typedef enum logic [1:0] {
    REG_PEND = 2'd0,
    REG_EN   = 2'd1,
    REG_LVL  = 2'd2,
    REG_CTRL = 2'd3
  } reg_sel_e;

  localparam int CTRL_GIE = 0;
  localparam int CTRL_ISR_LO = 1;
  localparam int CTRL_ISR_HI = 2;
endpackage

// File: rtl/irq_edge_sync.sv
module irq_edge_sync #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  output logic [N-1:0] edge_o
);
  for (genvar g = 0; g < N; g++) begin : g_src
    logic s1_q, s2_q, s3_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
        s3_q <= 1'b0;
      end else begin
        s1_q <= req_i[g];
        s2_q <= s1_q;
        s3_q <= s2_q;
      end
    end
    assign edge_o[g] = s2_q & ~s3_q;
  end
endmodule

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] pend_q;

  // set beats clear so no event is dropped
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~clr_i) | set_i;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int N    = 8,
  parameter int IdxW = 3
) (
  input  logic [N-1:0]    pend_i,
  input  logic [N-1:0]    en_i,
  input  logic [N-1:0]    lvl_i,
  output logic            valid_o,
  output logic            hi_o,
  output logic [IdxW-1:0] idx_o
);
  logic [N-1:0]    elig_hi, elig_lo;
  logic [IdxW-1:0] idx_hi, idx_lo;

  assign elig_hi = pend_i & en_i & lvl_i;
  assign elig_lo = pend_i & en_i & ~lvl_i;

  always_comb begin
    idx_hi = '0;
    idx_lo = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (elig_hi[i]) idx_hi = IdxW'(i);
      if (elig_lo[i]) idx_lo = IdxW'(i);
    end
  end

  assign hi_o    = |elig_hi;
  assign valid_o = |elig_hi | |elig_lo;
  assign idx_o   = hi_o ? idx_hi : idx_lo;
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int N = 8
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic [N-1:0]                       req_i,
  input  logic                               wr_en_i,
  input  logic [1:0]                         wr_addr_i,
  input  logic [N-1:0]                       wr_data_i,
  input  logic [1:0]                         rd_addr_i,
  output logic [N-1:0]                       rd_data_o,
  output logic                               irq_o,
  output logic [((N > 1) ? $clog2(N) : 1)-1:0] vec_o,
  input  logic                               ack_i,
  input  logic                               reti_i
);
  localparam int IdxW = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]    edge_w, pend_q, clr_w, ack_clr;
  logic [N-1:0]    en_q, lvl_q;
  logic            gie_q, isr_lo_q, isr_hi_q;
  logic            irq_q, grp_q;
  logic [IdxW-1:0] vec_q;
  logic            cand_valid, cand_hi;
  logic [IdxW-1:0] cand_idx;
  logic            take, acked, wr_pend, wr_en_reg, wr_lvl, wr_ctrl;

  irq_edge_sync #(.N(N)) sync_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .req_i (req_i),
    .edge_o(edge_w)
  );

  assign acked = irq_q & ack_i;

  always_comb begin
    ack_clr = '0;
    if (acked) ack_clr[vec_q] = 1'b1;
  end

  assign wr_pend   = wr_en_i && (wr_addr_i == REG_PEND);
  assign wr_en_reg = wr_en_i && (wr_addr_i == REG_EN);
  assign wr_lvl    = wr_en_i && (wr_addr_i == REG_LVL);
  assign wr_ctrl   = wr_en_i && (wr_addr_i == REG_CTRL);
  assign clr_w     = ack_clr | (wr_pend ? wr_data_i : '0);

  irq_pend_bank #(.N(N)) pend_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (edge_w),
    .clr_i (clr_w),
    .pend_o(pend_q)
  );

  irq_pick #(.N(N), .IdxW(IdxW)) pick_i (
    .pend_i (pend_q),
    .en_i   (en_q),
    .lvl_i  (lvl_q),
    .valid_o(cand_valid),
    .hi_o   (cand_hi),
    .idx_o  (cand_idx)
  );

  // idle service, or high group over a low handler
  assign take = gie_q && cand_valid && !irq_q &&
                ((!isr_lo_q && !isr_hi_q) || (cand_hi && isr_lo_q && !isr_hi_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '0;
      lvl_q <= '0;
    end else begin
      if (wr_en_reg) en_q  <= wr_data_i;
      if (wr_lvl)    lvl_q <= wr_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q <= 1'b0;
      vec_q <= '0;
      grp_q <= 1'b0;
    end else if (take) begin
      irq_q <= 1'b1;
      vec_q <= cand_idx;
      grp_q <= cand_hi;
    end else if (acked) begin
      irq_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gie_q    <= 1'b0;
      isr_lo_q <= 1'b0;
      isr_hi_q <= 1'b0;
    end else begin
      if (acked) begin
        gie_q <= 1'b0;
        if (grp_q) isr_hi_q <= 1'b1;
        else       isr_lo_q <= 1'b1;
      end else if (reti_i) begin
        gie_q <= 1'b1;
        if (isr_hi_q) isr_hi_q <= 1'b0;
        else          isr_lo_q <= 1'b0;
      end else if (wr_ctrl) begin
        gie_q <= wr_data_i[CTRL_GIE];
      end
    end
  end

  always_comb begin
    rd_data_o = '0;
    unique case (rd_addr_i)
      REG_PEND: rd_data_o = pend_q;
      REG_EN:   rd_data_o = en_q;
      REG_LVL:  rd_data_o = lvl_q;
      default: begin
        rd_data_o[CTRL_GIE]    = gie_q;
        rd_data_o[CTRL_ISR_LO] = isr_lo_q;
        rd_data_o[CTRL_ISR_HI] = isr_hi_q;
      end
    endcase
  end

  assign irq_o = irq_q;
  assign vec_o = vec_q;
endmodule

// File: rtl/irq_vec_ctrl_chk.sv
module irq_vec_ctrl_chk #(
  parameter int N    = 8,
  parameter int IdxW = 3
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            irq_o,
  input logic [IdxW-1:0] vec_o,
  input logic            ack_i,
  input logic            reti_i,
  input logic            gie_q,
  input logic            isr_hi_q,
  input logic [N-1:0]    pend_q,
  input logic [N-1:0]    edge_w
);
  // R6
  vec_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !ack_i |=> irq_o && $stable(vec_o));

  // R5
  gie_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(gie_q) && !$past(isr_hi_q));

  // R6
  ack_gie_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && ack_i |=> !gie_q && !irq_o);

  // R6
  ack_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && ack_i && !edge_w[vec_o] |=> !pend_q[$past(vec_o)]);

  // R9
  reti_gie_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reti_i && !(irq_o && ack_i) |=> gie_q);

  for (genvar g = 0; g < N; g++) begin : g_bit
    // R1
    no_spurious_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !pend_q[g] && !edge_w[g] |=> !pend_q[g]);
    // R10
    set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      edge_w[g] |=> pend_q[g]);
  end
endmodule

bind irq_vec_ctrl irq_vec_ctrl_chk #(.N(N), .IdxW(IdxW)) chk_i (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .irq_o   (irq_o),
  .vec_o   (vec_o),
  .ack_i   (ack_i),
  .reti_i  (reti_i),
  .gie_q   (gie_q),
  .isr_hi_q(isr_hi_q),
  .pend_q  (pend_q),
  .edge_w  (edge_w)
);

// File: tb/irq_vec_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_vec_ctrl_tb_top;
  localparam int N = 8;
  localparam int IdxW = 3;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [N-1:0]    req = '0;
  logic            wr_en = 1'b0;
  logic [1:0]      wr_addr = '0;
  logic [N-1:0]    wr_data = '0;
  logic [1:0]      rd_addr = '0;
  logic [N-1:0]    rd_data;
  logic            irq;
  logic [IdxW-1:0] vec;
  logic            ack = 1'b0;
  logic            reti = 1'b0;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [N-1:0] m_pend = '0, m_en = '0, m_lvl = '0;

  always #2.5 clk = ~clk;

  irq_vec_ctrl #(.N(N)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .irq_o(irq), .vec_o(vec), .ack_i(ack), .reti_i(reti)
  );

  task automatic chk(input string req_tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req_tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [N-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [N-1:0] d);
    @(negedge clk);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  task automatic pulse(input logic [N-1:0] m);
    @(negedge clk);
    req = req | m;
    @(negedge clk);
    req = req & ~m;
    wait_cyc(4);
    m_pend = m_pend | m;
  endtask

  task automatic do_ack();
    @(negedge clk);
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
  endtask

  task automatic do_reti();
    @(negedge clk);
    reti = 1'b1;
    @(negedge clk);
    reti = 1'b0;
  endtask

  // group first, then lowest index; -1 when nothing eligible
  function automatic int pick(logic [N-1:0] p, logic [N-1:0] e, logic [N-1:0] l);
    int r = -1;
    for (int i = N - 1; i >= 0; i--) if (p[i] && e[i] && !l[i]) r = i;
    for (int i = N - 1; i >= 0; i--) if (p[i] && e[i] && l[i]) r = i;
    return r;
  endfunction

  // serve the whole backlog with gie on at entry
  task automatic drain(input string tag);
    int exp_v;
    logic [N-1:0] d;
    exp_v = pick(m_pend, m_en, m_lvl);
    while (exp_v >= 0) begin
      wait_cyc(3);
      chk({tag, " irq"}, int'(irq), 1);
      chk({tag, " vec"}, int'(vec), exp_v);
      do_ack();
      m_pend[exp_v] = 1'b0;
      rd(2'd3, d);
      // R6: gie off, group in-service bit set
      chk("R6 ctrl after ack", int'(d[2:0]), m_lvl[exp_v] ? 4 : 2);
      chk("R6 irq dropped", int'(irq), 0);
      do_reti();
      rd(2'd3, d);
      chk("R9 ctrl after reti", int'(d[2:0]), 1);
      exp_v = pick(m_pend, m_en, m_lvl);
    end
    wait_cyc(3);
    chk("R5 idle when nothing eligible", int'(irq), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] d, r, c;
    void'($urandom(32'd4711));
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(2);

    // R11 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      chk("R11 reset", int'(d), 0);
    end
    chk("R11 reset irq", int'(irq), 0);

    // R2 latch while disabled
    pulse(8'h94);
    rd(2'd0, d);
    chk("R2 latch while masked", int'(d), 'h94);
    wait_cyc(3);
    chk("R5 no irq while gie off", int'(irq), 0);

    // R3 simultaneous, index order
    m_en = '1; wr(2'd1, m_en);
    wr(2'd3, 8'h01);
    drain("R3 simultaneous");

    // R1 held level sets once
    wr(2'd3, 8'h00);
    @(negedge clk); req[4] = 1'b1;
    wait_cyc(5);
    m_pend[4] = 1'b1;
    wr(2'd0, 8'h10); m_pend[4] = 1'b0;
    wait_cyc(4);
    rd(2'd0, d);
    chk("R1 held level no re-set", int'(d), 0);
    @(negedge clk); req[4] = 1'b0;
    wait_cyc(3);

    // R10 W1C plain, then same-cycle set vs clear on bit 2
    pulse(8'h06);
    wr(2'd0, 8'h02); m_pend[1] = 1'b0;
    rd(2'd0, d);
    chk("R10 clear by write", int'(d), 'h04);
    @(negedge clk); req[2] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'd0; wr_data = 8'h04;
    @(negedge clk); wr_en = 1'b0; req[2] = 1'b0;
    rd(2'd0, d);
    chk("R10 event wins over clear", int'(d), 'h04);
    wr(2'd0, 8'hFF); m_pend = '0;

    // R3 masked then enabled
    m_en = 8'hF7; wr(2'd1, m_en);
    pulse(8'h48);
    wr(2'd3, 8'h01);
    wait_cyc(3);
    chk("R3 masked source skipped", int'(vec), 6);
    do_ack(); m_pend[6] = 1'b0; do_reti();
    wait_cyc(3);
    chk("R3 masked source idle", int'(irq), 0);
    m_en = '1; wr(2'd1, m_en);
    wait_cyc(3);
    chk("R3 re-enabled served", int'(vec), 3);
    chk("R3 re-enabled irq", int'(irq), 1);
    do_ack(); m_pend[3] = 1'b0; do_reti();

    // R8 preemption across groups
    wr(2'd3, 8'h00);
    m_lvl = 8'h20; wr(2'd2, m_lvl);
    pulse(8'h02);
    wr(2'd3, 8'h01);
    wait_cyc(3);
    chk("R4 low src presented", int'(vec), 1);
    do_ack(); m_pend[1] = 1'b0;
    wr(2'd3, 8'h01);
    pulse(8'h01);
    wait_cyc(3);
    chk("R8 equal level no preempt", int'(irq), 0);
    pulse(8'h20);
    wait_cyc(3);
    chk("R8 high preempts", int'(irq), 1);
    chk("R8 high vec", int'(vec), 5);
    do_ack(); m_pend[5] = 1'b0;
    rd(2'd3, d);
    chk("R6 both in service", int'(d[2:0]), 6);
    do_reti();
    rd(2'd3, d);
    chk("R9 unwinds high first", int'(d[2:0]), 3);
    wait_cyc(3);
    chk("R8 low blocked under low handler", int'(irq), 0);
    do_reti();
    wait_cyc(3);
    chk("R7 backlog after return", int'(vec), 0);
    do_ack(); m_pend[0] = 1'b0; do_reti();
    wait_cyc(3);
    wr(2'd3, 8'h00);

    // R4 R7 random backlog
    for (int it = 0; it < 40; it++) begin
      m_en = 8'($urandom); wr(2'd1, m_en);
      m_lvl = 8'($urandom); wr(2'd2, m_lvl);
      r = 8'($urandom);
      pulse(r);
      if (it % 4 == 0) begin
        c = 8'($urandom);
        wr(2'd0, c);
        m_pend = m_pend & ~c;
      end
      rd(2'd0, d);
      chk("R2 random backlog", int'(d), int'(m_pend));
      wr(2'd3, 8'h01);
      drain("R7 random");
      wr(2'd3, 8'h00);
      wr(2'd0, 8'hFF); m_pend = '0;
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule